// File: doc/BRIEF.md
# Decode-Stage Interlock and Branch Squash Controller

This block sits beside the decode stage of a five-stage in-order pipeline and decides, every cycle, whether the front of the pipe may advance. It compares the two source register numbers of the instruction now in decode against the destination of the instruction one stage ahead in execute. If that older instruction is a memory read and its destination is one of those sources, the loaded value cannot reach the consumer in time. The unit then holds the program counter and the fetch/decode register for one cycle and asks the decode stage to send an all-zero control word (a bubble) into execute in place of the consumer. Only the adjacent instruction is checked. A consumer two or more slots behind the load is served by the forwarding paths, which are not part of this block.

Branches are assumed not taken, and a comparator in decode resolves them. When that comparator reports a taken branch, the unit raises a squash strobe. The strobe turns the instruction fetched behind the branch into a no-op, so a taken branch costs one cycle. The strobe fires for one cycle per branch event, even when the taken indication stays high longer. A squash overrides an interlock raised in the same cycle. Register 0 is hardwired to zero, so a load that targets it never interlocks.

Top module: `hazard_ctl`

## Requirements
- R1: When `ex_is_load_i` is 1, `ex_dst_i` is nonzero, `ex_dst_i` equals `src_rs_i` and no squash is raised, then in that same cycle `pc_en_o`=0, `fdreg_en_o`=0 and `bubble_o`=1.
- R2: The same interlock as R1 occurs when `ex_dst_i` equals `src_rt_i`, whatever `src_rs_i` holds.
- R3: When `ex_is_load_i` is 0, no interlock occurs even if the register numbers match: `pc_en_o`=1, `fdreg_en_o`=1, `bubble_o`=0.
- R4: A load whose destination is register 0 never interlocks, even when a source is also register 0.
- R5: A load whose destination matches neither source does not interlock.
- R6: In a cycle where `br_taken_i` is 1 and was 0 in the previous cycle (or reset was just released), `flush_o` is 1 in that same cycle.
- R7: `flush_o` is high for exactly one cycle per taken-branch event. If `br_taken_i` stays 1 on consecutive cycles, only the first cycle flushes. After one cycle with `br_taken_i` at 0 the strobe can fire again. In a held cycle that does not flush, the interlock logic works normally.
- R8: When a squash and an interlock condition occur in the same cycle, the squash wins: `flush_o`=1, `pc_en_o`=1, `fdreg_en_o`=1, `bubble_o`=0.
- R9: After synchronous reset, with no load and no taken branch, the unit lets the pipe advance: `pc_en_o`=1, `fdreg_en_o`=1, `bubble_o`=0, `flush_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_rs_i | input | REG_W | First source register of the instruction in decode |
| src_rt_i | input | REG_W | Second source register of the instruction in decode |
| ex_dst_i | input | REG_W | Load destination register of the instruction in execute |
| ex_is_load_i | input | 1 | Instruction in execute reads data memory |
| br_taken_i | input | 1 | Decode-stage branch comparator reports taken |
| pc_en_o | output | 1 | Program counter may update |
| fdreg_en_o | output | 1 | Fetch/decode pipeline register may load |
| bubble_o | output | 1 | Force zero control word into execute |
| flush_o | output | 1 | Squash the instruction in the fetch/decode register |

## Verification
The hardest case to reach from the ports is a cycle in which the taken indication is still high from the previous cycle while a load-use match is present. In that cycle the one-shot has already fired, so the interlock must take effect, even though a cycle earlier the same inputs would have been overridden by the squash. The stimulus holds the taken input high over two steps and presents a matching load in the second step. It also applies a fresh taken edge together with a matching load, to show the squash winning. A sweep over every destination register, with a load whose source matches it, covers register 0 against all the others.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // number of source operands compared per decoded instruction
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic pc_en;
    logic fdreg_en;
    logic bubble;
    logic flush;
  } hz_ctl_t;
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hazard_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [REG_W-1:0]              dst_i,
  input  logic                          is_load_i,
  output logic                          stall_o
);
  logic [NUM_SRC-1:0] hit;
  logic               dst_live;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign hit[i] = (src_i[i] == dst_i);
  end

  if (ZERO_HARD) begin : g_zero
    assign dst_live = (dst_i != '0);
  end else begin : g_nozero
    assign dst_live = 1'b1;
  end

  assign stall_o = is_load_i & dst_live & (|hit);
endmodule

// File: rtl/hz_flush_once.sv
module hz_flush_once (
  input  logic clk,
  input  logic rst,
  input  logic taken_i,
  output logic flush_o
);
  logic taken_q;

  always_ff @(posedge clk) begin
    if (rst) taken_q <= 1'b0;
    else     taken_q <= taken_i;
  end

  assign flush_o = taken_i & ~taken_q;
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hazard_pkg::*;
(
  input  logic    stall_req_i,
  input  logic    flush_req_i,
  output hz_ctl_t ctl_o
);
  always_comb begin
    ctl_o.flush    = flush_req_i;
    ctl_o.pc_en    = 1'b1;
    ctl_o.fdreg_en = 1'b1;
    ctl_o.bubble   = 1'b0;
    if (!flush_req_i && stall_req_i) begin
      ctl_o.pc_en    = 1'b0;
      ctl_o.fdreg_en = 1'b0;
      ctl_o.bubble   = 1'b1;
    end
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src_rs_i,
  input  logic [REG_W-1:0] src_rt_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_is_load_i,
  input  logic             br_taken_i,
  output logic             pc_en_o,
  output logic             fdreg_en_o,
  output logic             bubble_o,
  output logic             flush_o
);
  logic [NUM_SRC-1:0][REG_W-1:0] srcs;
  logic    stall_req;
  logic    flush_req;
  hz_ctl_t ctl;

  assign srcs[0] = src_rs_i;
  assign srcs[1] = src_rt_i;

  hz_loaduse #(.REG_W(REG_W), .ZERO_HARD(1'b1)) u_lu (
    .src_i    (srcs),
    .dst_i    (ex_dst_i),
    .is_load_i(ex_is_load_i),
    .stall_o  (stall_req)
  );

  hz_flush_once u_fl (
    .clk    (clk),
    .rst    (rst),
    .taken_i(br_taken_i),
    .flush_o(flush_req)
  );

  hz_arbiter u_arb (
    .stall_req_i(stall_req),
    .flush_req_i(flush_req),
    .ctl_o      (ctl)
  );

  assign pc_en_o    = ctl.pc_en;
  assign fdreg_en_o = ctl.fdreg_en;
  assign bubble_o   = ctl.bubble;
  assign flush_o    = ctl.flush;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] src_rs_i,
  input logic [REG_W-1:0] src_rt_i,
  input logic [REG_W-1:0] ex_dst_i,
  input logic             ex_is_load_i,
  input logic             br_taken_i,
  input logic             pc_en_o,
  input logic             fdreg_en_o,
  input logic             bubble_o,
  input logic             flush_o
);
  a_r1_rs_interlock: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load_i && ex_dst_i != '0 && ex_dst_i == src_rs_i && !flush_o)
      |-> (!pc_en_o && !fdreg_en_o && bubble_o));

  a_r2_rt_interlock: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load_i && ex_dst_i != '0 && ex_dst_i == src_rt_i && !flush_o)
      |-> (!pc_en_o && !fdreg_en_o && bubble_o));

  a_r3_no_load_free: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load_i |-> (pc_en_o && fdreg_en_o && !bubble_o));

  a_r4_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (ex_dst_i == '0) |-> !bubble_o);

  a_r5_no_match: assert property (@(posedge clk) disable iff (rst)
    (ex_dst_i != src_rs_i && ex_dst_i != src_rt_i) |-> !bubble_o);

  a_r6_edge_flush: assert property (@(posedge clk) disable iff (rst)
    $rose(br_taken_i) |-> flush_o);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  a_r7_needs_taken: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> br_taken_i);

  a_r8_flush_wins: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (pc_en_o && fdreg_en_o && !bubble_o));
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;
  localparam int REG_W = 5;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] rs = '0, rt = '0, dst = '0;
  logic ld = 1'b0, bt = 1'b0;
  logic pc_en, fd_en, bubble, flush;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  logic prev_bt = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctl #(.REG_W(REG_W)) uut (
    .clk(clk), .rst(rst), .src_rs_i(rs), .src_rt_i(rt), .ex_dst_i(dst),
    .ex_is_load_i(ld), .br_taken_i(bt), .pc_en_o(pc_en), .fdreg_en_o(fd_en),
    .bubble_o(bubble), .flush_o(flush)
  );

  // expected {pc_en, fdreg_en, bubble, flush} from the requirements
  task automatic step(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                      input logic [REG_W-1:0] d, input logic l, input logic t,
                      input string tag);
    item_t it;
    logic fl, st;
    @(posedge clk);
    #1;
    rs = a; rt = b; dst = d; ld = l; bt = t;
    fl = t & ~prev_bt;
    st = l && d != '0 && (d == a || d == b);
    prev_bt = t;
    if (fl)      it.exp = 4'b1101;
    else if (st) it.exp = 4'b0010;
    else         it.exp = 4'b1100;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: sample at the falling edge, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        act = {pc_en, fd_en, bubble, flush};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    prev_bt = 1'b0;
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R9 idle after reset");
    step(5'd3, 5'd7, 5'd3, 1'b1, 1'b0, "R1 load dst matches rs");
    step(5'd9, 5'd12, 5'd12, 1'b1, 1'b0, "R2 load dst matches rt");
    step(5'd6, 5'd6, 5'd6, 1'b1, 1'b0, "R1 R2 both sources match");
    step(5'd4, 5'd4, 5'd4, 1'b0, 1'b0, "R3 match without load");
    step(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, "R4 load to reg0");
    step(5'd1, 5'd2, 5'd30, 1'b1, 1'b0, "R5 load no match");
    step(5'd1, 5'd2, 5'd3, 1'b0, 1'b1, "R6 taken branch flushes");
    step(5'd1, 5'd2, 5'd3, 1'b0, 1'b1, "R7 held taken no second flush");
    step(5'd8, 5'd2, 5'd8, 1'b1, 1'b1, "R7 held taken lets interlock act");
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R9 idle between branches");
    step(5'd1, 5'd2, 5'd3, 1'b0, 1'b1, "R7 re-armed flush");
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R9 idle");
    step(5'd11, 5'd2, 5'd11, 1'b1, 1'b1, "R8 flush beats interlock");
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R9 idle");
    for (int i = 0; i < (1 << REG_W); i++) begin
      step(i[REG_W-1:0], 5'd17, i[REG_W-1:0], 1'b1, 1'b0,
           (i == 0) ? "R4 sweep reg0" : "R1 sweep dst");
    end
    for (int i = 1; i < (1 << REG_W); i++) begin
      step(5'd0, i[REG_W-1:0], i[REG_W-1:0], 1'b1, 1'b0, "R2 sweep dst");
    end
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R9 final idle");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule